// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Snapshot

This block keeps elapsed time as two counters: a sub-second count that advances on every pulse of a one-millisecond strobe, and a seconds count that advances each time the sub-second count rolls over. Software reaches both through a small memory-mapped register port with one-cycle registered read data.

Seconds and milliseconds live in separate registers, so two separate reads could straddle a rollover and give an inconsistent pair. To prevent this, a read of the millisecond register also copies the seconds count into a snapshot register on the same clock edge. Software reads milliseconds first and then the snapshot. It forms the time as snapshot × 1000 + milliseconds, and that figure always describes one instant. The live seconds count can also be read directly, and a write to it presets the seconds value.

Top module: `rtc_shadow_clock`

## Requirements
- R1: A synchronous active-high reset clears the millisecond count, the seconds count, the snapshot, the read data and the read-valid flag.
- R2: Each clock with the tick strobe high advances the millisecond count by one from 0 up to MS_PER_SEC-1 (1000 by default), and the next tick returns it to 0.
- R3: The seconds count rises by one on the tick that returns the millisecond count to 0 and wraps modulo 2^SEC_W (32 bits by default). It does not change on any other clock unless written.
- R4: A read at offset 0x10 returns the millisecond count as it was before that clock's tick. On the same edge, the seconds count as it was before that tick is captured into the snapshot.
- R5: A read at offset 0x0C returns the snapshot. The snapshot keeps its value through ticks, rollovers and seconds writes until the next read at offset 0x10.
- R6: A read at offset 0x08 returns the live seconds count. A write at offset 0x08 loads the write data into the seconds count. When that write coincides with a rollover tick, the written value is kept and the millisecond count still returns to 0.
- R7: Writes to offsets 0x10, 0x0C and any unmapped offset change no state. A read of an unmapped offset returns 0.
- R8: Read data and the read-valid flag appear on the clock after the read request. A write request never raises the read-valid flag.
- R9: A read at 0x10 followed by a read at 0x0C gives snapshot × MS_PER_SEC + milliseconds equal to the total number of ticks taken before the 0x10 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata carries a read result |

## Verification
A corrupted millisecond or seconds count shows up on the next read of offset 0x10 or 0x08. It also breaks the snapshot × MS_PER_SEC + milliseconds identity on the following pair of reads. A snapshot that is captured at the wrong edge, or that drifts between captures, shows up on the next 0x0C read as a value off by one or more seconds. The bench uses a five-tick second and reads after every tick, so any of these faults appears within one or two bus accesses of the cycle where it occurs.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  // Byte offsets of the registers; software reads MS then SHADOW.
  localparam logic [7:0] OFS_LIVE_SEC   = 8'h08;
  localparam logic [7:0] OFS_SHADOW_SEC = 8'h0C;
  localparam logic [7:0] OFS_MS         = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LIVE,
    SEL_SHADOW,
    SEL_MS
  } reg_sel_e;
endpackage

// File: rtl/rtc_ms_counter.sv
module rtc_ms_counter #(
  parameter int MS_PER_SEC = 1000,
  localparam int MS_W = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [MS_W-1:0] ms_cnt,
  output logic            carry
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  assign carry = tick && (ms_cnt == MS_LAST);

  always_ff @(posedge clk) begin
    if (rst)        ms_cnt <= '0;
    else if (carry) ms_cnt <= '0;
    else if (tick)  ms_cnt <= ms_cnt + 1'b1;
  end

  // R2: count stays inside its range
  a_r2_ms_range: assert property (@(posedge clk) disable iff (rst)
    ms_cnt <= MS_LAST);
  // R2: a tick on the last value returns to zero
  a_r2_ms_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && ms_cnt == MS_LAST) |=> (ms_cnt == '0));
  // R2: no tick, no change
  a_r2_ms_idle: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ms_cnt));
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] sec_cnt
);
  always_ff @(posedge clk) begin
    if (rst)       sec_cnt <= '0;
    else if (load) sec_cnt <= load_val;
    else if (inc)  sec_cnt <= sec_cnt + 1'b1;
  end

  // R3: one step per rollover, modulo 2^SEC_W
  a_r3_sec_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (sec_cnt == $past(sec_cnt) + SEC_W'(1)));
  // R3: no rollover and no write, no change
  a_r3_sec_idle: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(sec_cnt));
  // R6: a write wins over a rollover
  a_r6_sec_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (sec_cnt == $past(load_val)));
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MS_W-1:0]   ms_cnt,
  input  logic [SEC_W-1:0]  sec_cnt,
  output logic              sec_load,
  output logic [SEC_W-1:0]  sec_load_val,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  reg_sel_e          sel;
  logic              rd_en;
  logic              snap_en;
  logic [SEC_W-1:0]  shadow_sec;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if      (addr == ADDR_W'(OFS_LIVE_SEC))   sel = SEL_LIVE;
    else if (addr == ADDR_W'(OFS_SHADOW_SEC)) sel = SEL_SHADOW;
    else if (addr == ADDR_W'(OFS_MS))         sel = SEL_MS;
    else                                      sel = SEL_NONE;
  end

  assign rd_en        = req && !we;
  assign snap_en      = rd_en && (sel == SEL_MS);
  assign sec_load     = req && we && (sel == SEL_LIVE);
  assign sec_load_val = SEC_W'(wdata);

  always_comb begin
    unique case (sel)
      SEL_LIVE:   rd_mux = DATA_W'(sec_cnt);
      SEL_SHADOW: rd_mux = DATA_W'(shadow_sec);
      SEL_MS:     rd_mux = DATA_W'(ms_cnt);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_sec <= '0;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en)   rdata      <= rd_mux;
      if (snap_en) shadow_sec <= sec_cnt;
    end
  end

  // R4: snapshot taken on the millisecond read edge
  a_r4_snap_capture: assert property (@(posedge clk) disable iff (rst)
    snap_en |=> (shadow_sec == $past(sec_cnt)));
  // R5: snapshot holds between millisecond reads
  a_r5_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !snap_en |=> $stable(shadow_sec));
  // R8: read answered on the next clock
  a_r8_rvalid_read: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  // R8: a write never raises rvalid
  a_r8_rvalid_write: assert property (@(posedge clk) disable iff (rst)
    (req && we) |=> !rvalid);
endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock #(
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  localparam int MS_W = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  logic [MS_W-1:0]  ms_cnt;
  logic             ms_carry;
  logic [SEC_W-1:0] sec_cnt;
  logic             sec_load;
  logic [SEC_W-1:0] sec_load_val;

  rtc_ms_counter #(.MS_PER_SEC(MS_PER_SEC)) u_ms (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_ms),
    .ms_cnt (ms_cnt),
    .carry  (ms_carry)
  );

  rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
    .clk      (clk),
    .rst      (rst),
    .inc      (ms_carry),
    .load     (sec_load),
    .load_val (sec_load_val),
    .sec_cnt  (sec_cnt)
  );

  rtc_reg_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEC_W  (SEC_W),
    .MS_W   (MS_W)
  ) u_port (
    .clk          (clk),
    .rst          (rst),
    .req          (bus_req),
    .we           (bus_we),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .ms_cnt       (ms_cnt),
    .sec_cnt      (sec_cnt),
    .sec_load     (sec_load),
    .sec_load_val (sec_load_val),
    .rdata        (bus_rdata),
    .rvalid       (bus_rvalid)
  );

  // R1: reset leaves the read port idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/sim_rtc_shadow_clock.sv
`timescale 1ns/1ps
module sim_rtc_shadow_clock;
  localparam int MSPS = 5;
  localparam logic [7:0] A_LIVE = 8'h08, A_SHAD = 8'h0C, A_MS = 8'h10, A_BAD = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_ms = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int fails = 0;
  int          m_ms = 0;
  logic [31:0] m_sec = '0;
  logic [31:0] m_shad = '0;
  logic [31:0] last_rd;
  longint      ticks_total = 0;

  always #4 clk = ~clk;

  rtc_shadow_clock #(.MS_PER_SEC(MSPS)) u0 (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One clock: drive at negedge, update the arithmetic model, sample at next negedge.
  task automatic cyc(input string rq, input logic tk, input logic rq_en, input logic wr,
                     input logic [7:0] ad, input logic [31:0] wd);
    logic [31:0] exp_rd;
    logic        is_rd;
    tick_ms = tk; bus_req = rq_en; bus_we = wr; bus_addr = ad; bus_wdata = wd;
    is_rd = rq_en && !wr;
    case (ad)
      A_LIVE:  exp_rd = m_sec;
      A_SHAD:  exp_rd = m_shad;
      A_MS:    exp_rd = 32'(m_ms);
      default: exp_rd = '0;
    endcase
    if (is_rd && ad == A_MS) m_shad = m_sec;
    if (rq_en && wr && ad == A_LIVE) m_sec = wd;
    else if (tk && m_ms == MSPS-1) m_sec = m_sec + 1;
    if (tk) begin
      m_ms = (m_ms + 1) % MSPS;
      ticks_total++;
    end
    @(posedge clk);
    @(negedge clk);
    tick_ms = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    chk({rq, " R8 rvalid"}, {31'd0, bus_rvalid}, {31'd0, is_rd});
    if (is_rd) begin
      chk(rq, bus_rdata, exp_rd);
      last_rd = bus_rdata;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ms_rd;
    longint      t_at;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
    cyc("R1 ms after reset",     1'b0, 1'b1, 1'b0, A_MS,   '0);
    cyc("R1 sec after reset",    1'b0, 1'b1, 1'b0, A_LIVE, '0);
    cyc("R1 shadow after reset", 1'b0, 1'b1, 1'b0, A_SHAD, '0);

    // R2 R3 R9: sweep several seconds, coherent pair after every tick
    for (int i = 0; i < 4 * MSPS + 3; i++) begin
      cyc("R2 tick", 1'b1, 1'b0, 1'b0, '0, '0);
      t_at = ticks_total;
      cyc("R2 ms read", 1'b0, 1'b1, 1'b0, A_MS, '0);
      ms_rd = last_rd;
      cyc("R5 shadow read during tick", 1'b1, 1'b1, 1'b0, A_SHAD, '0);
      chk("R9 coherent pair", last_rd * MSPS + ms_rd, 32'(t_at));
      cyc("R3 live sec", 1'b0, 1'b1, 1'b0, A_LIVE, '0);
    end

    // R4: read ms on the same clock as a rollover tick
    while (m_ms != MSPS-1) cyc("R2 advance", 1'b1, 1'b0, 1'b0, '0, '0);
    cyc("R4 ms read with rollover tick", 1'b1, 1'b1, 1'b0, A_MS, '0);
    cyc("R4 shadow holds pre-tick seconds", 1'b0, 1'b1, 1'b0, A_SHAD, '0);
    cyc("R3 seconds after rollover", 1'b0, 1'b1, 1'b0, A_LIVE, '0);

    // R5: snapshot holds across ticks, rollover and a seconds write
    for (int i = 0; i < 2 * MSPS; i++) cyc("R5 ticks", 1'b1, 1'b0, 1'b0, '0, '0);
    cyc("R5 preset", 1'b0, 1'b1, 1'b1, A_LIVE, 32'd777);
    cyc("R5 shadow held", 1'b0, 1'b1, 1'b0, A_SHAD, '0);
    cyc("R6 preset readback", 1'b0, 1'b1, 1'b0, A_LIVE, '0);

    // R6: write coinciding with a rollover tick
    while (m_ms != MSPS-1) cyc("R2 advance", 1'b1, 1'b0, 1'b0, '0, '0);
    cyc("R6 write on rollover", 1'b1, 1'b1, 1'b1, A_LIVE, 32'd100);
    cyc("R6 write wins", 1'b0, 1'b1, 1'b0, A_LIVE, '0);
    cyc("R6 ms back to zero", 1'b0, 1'b1, 1'b0, A_MS, '0);

    // R3: seconds wrap at 2^32
    cyc("R3 preset max", 1'b0, 1'b1, 1'b1, A_LIVE, 32'hFFFF_FFFF);
    while (m_ms != MSPS-1) cyc("R2 advance", 1'b1, 1'b0, 1'b0, '0, '0);
    cyc("R3 wrap tick", 1'b1, 1'b0, 1'b0, '0, '0);
    cyc("R3 seconds wrapped", 1'b0, 1'b1, 1'b0, A_LIVE, '0);

    // R7: ignored writes, unmapped reads
    cyc("R2 tick", 1'b1, 1'b0, 1'b0, '0, '0);
    cyc("R7 write ms", 1'b0, 1'b1, 1'b1, A_MS, 32'h3);
    cyc("R7 ms unchanged", 1'b0, 1'b1, 1'b0, A_MS, '0);
    cyc("R7 write shadow", 1'b0, 1'b1, 1'b1, A_SHAD, 32'h55);
    cyc("R7 shadow unchanged", 1'b0, 1'b1, 1'b0, A_SHAD, '0);
    cyc("R7 write unmapped", 1'b0, 1'b1, 1'b1, A_BAD, 32'h99);
    cyc("R7 sec unchanged", 1'b0, 1'b1, 1'b0, A_LIVE, '0);
    cyc("R7 unmapped read", 1'b0, 1'b1, 1'b0, A_BAD, '0);

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_ms = 0; m_sec = '0; m_shad = '0;
    chk("R1 rvalid after second reset", {31'd0, bus_rvalid}, 32'd0);
    cyc("R1 ms cleared", 1'b0, 1'b1, 1'b0, A_MS, '0);
    cyc("R1 shadow cleared", 1'b0, 1'b1, 1'b0, A_SHAD, '0);
    cyc("R1 sec cleared", 1'b0, 1'b1, 1'b0, A_LIVE, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule